// File: doc/BRIEF.md
# Cascade Flag Unit for Content-Addressable Memory

This block produces the status flags of one content-addressable memory device that sits in a vertical chain of such devices. It watches an active-low cycle strobe and a chain-enable input that is sampled when the strobe falls. It also takes the local outcome of each compare cycle: how many entries hit, and whether the device still holds an empty location. From these it drives four active-low flags. The system match flag is gated by the chain and ripples down the cascade. The device match and multiple match flags are local to the device. The full flag also ripples down the cascade.

Devices are stacked by wiring each device's system match and full outputs into the match and full inputs of the next lower-priority device. The top device has its match input tied high and its full input tied low. The system-wide match and full indications are read from the last device. Two or more sets of flag-enable bits are kept. Any one of them can be written, and one of them is active at a time. Switching the active set wipes the match flags and the strobe state.

The strobe tracker is a four-state machine. IDLE means the strobe is high and the chain is off. LOW_OFF means the strobe is low and the chain enable was high at the falling edge. LOW_ON means the strobe is low and the chain enable was low at the falling edge. SHOW means the strobe is high after an enabled cycle, and the system match flag is valid. The transitions are:
- fall: IDLE or SHOW goes to LOW_ON or LOW_OFF, depending on the chain enable.
- rise_on: LOW_ON goes to SHOW.
- rise_off: LOW_OFF goes to IDLE.
- set_switch: any state goes to IDLE, and this transition overrides the others.

Top module: `cam_cascade_flags`

## Requirements
- R1: After reset the system match, device match and multiple match outputs are high, and every flag-enable bit of every set is 1.
- R2: A strobe fall with chain_en_n high (fall to LOW_OFF, then rise_off to IDLE) keeps sys_match_n high until the next fall.
- R3: While the strobe is low, sys_match_n is high. In SHOW with the active match enable at 1, sys_match_n is low when up_match_n is low or when the latest compare hit count is nonzero.
- R4: In SHOW with the active match enable at 0, sys_match_n equals up_match_n.
- R5: dev_match_n is low exactly when the hit count of the latest compare cycle or of the one before it is at least 1. The counts are taken at the clock edge where the strobe is first seen high after a low phase, provided cmp_done is 1 there.
- R6: multi_match_n is low exactly when either of those two hit counts is at least 2.
- R7: A strobe cycle whose rise sees cmp_done at 0 leaves dev_match_n and multi_match_n unchanged.
- R8: With the active full enable at 1, full_n = up_full_n OR has_empty. With it at 0, full_n = up_full_n.
- R9: A change of act_sel clears sys_match_n, dev_match_n and multi_match_n to high at the next edge, and it wins over a strobe rise in the same cycle, whose counts are discarded. The flags that follow use the new set's enables.
- R10: With cfg_we at 1, the set numbered cfg_idx takes cfg_match_en and cfg_full_en at the next edge. Other sets keep their bits.
- R11: In a chain of three devices, the last device's sys_match_n and full_n obey R3, R4 and R8 applied device by device from the top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_n | input | 1 | Active-low cycle strobe |
| chain_en_n | input | 1 | Active-low chain enable, sampled at strobe fall |
| up_match_n | input | 1 | Match from the higher-priority device |
| up_full_n | input | 1 | Full from the higher-priority device |
| cmp_done | input | 1 | Current strobe cycle is a compare |
| hit_count | input | CW | Local hit count, valid at strobe rise |
| has_empty | input | 1 | Device has an empty location |
| cfg_we | input | 1 | Enable-set write strobe |
| cfg_idx | input | SW | Set written |
| cfg_match_en | input | 1 | Match enable to write |
| cfg_full_en | input | 1 | Full enable to write |
| act_sel | input | SW | Active enable set |
| sys_match_n | output | 1 | Chain-gated match flag |
| dev_match_n | output | 1 | Local match flag |
| multi_match_n | output | 1 | Local multiple match flag |
| full_n | output | 1 | Chained full flag |

## Verification
Two events can land on the same clock edge: the strobe rise that commits a compare's hit counts, and a switch of the active enable set. The bench raises the strobe with nonzero hit counts on all three devices and changes act_sel in the same cycle. It then requires every match flag to read high and the following compare to see empty history. Around that case, near-exhaustive sweeps over chain enable, per-device match enables and hit counts compare each output with values the bench derives from the priority rules.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOW_OFF = 2'd1,
        ST_LOW_ON  = 2'd2,
        ST_SHOW    = 2'd3
    } chain_state_e;

    localparam int MULTI_THRESHOLD = 2;
endpackage

// File: rtl/cfc_strobe_fsm.sv
module cfc_strobe_fsm
    import cfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_n,
    input  logic chain_en_n,
    input  logic set_chg,
    output logic show,
    output logic commit
);
    chain_state_e state, state_nx;
    logic cyc_q;
    logic fall, rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_q <= 1'b1;
        else        cyc_q <= cyc_n;
    end

    assign fall = cyc_q & ~cyc_n;
    assign rise = ~cyc_q & cyc_n;

    // next state
    always_comb begin
        state_nx = state;
        if (set_chg) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_SHOW: if (fall) state_nx = chain_en_n ? ST_LOW_OFF : ST_LOW_ON;
                ST_LOW_OFF:       if (rise) state_nx = ST_IDLE;
                ST_LOW_ON:        if (rise) state_nx = ST_SHOW;
                default:          state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        show   = 1'b0;
        commit = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_LOW_OFF: commit = rise & ~set_chg;
            ST_LOW_ON:  commit = rise & ~set_chg;
            ST_SHOW:    show = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/cfc_hit_history.sv
module cfc_hit_history
    import cfc_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic          cmp_done,
    input  logic          set_chg,
    input  logic [CW-1:0] hit_count,
    output logic          any_cur,
    output logic          dev_match_n,
    output logic          multi_match_n
);
    localparam logic [CW-1:0] MULTI = CW'(MULTI_THRESHOLD);

    logic [CW-1:0] cur_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            prev_q <= '0;
        end else if (set_chg) begin
            cur_q  <= '0;
            prev_q <= '0;
        end else if (commit && cmp_done) begin
            prev_q <= cur_q;
            cur_q  <= hit_count;
        end
    end

    assign any_cur       = (cur_q != '0);
    assign dev_match_n   = ~((cur_q != '0) | (prev_q != '0));
    assign multi_match_n = ~((cur_q >= MULTI) | (prev_q >= MULTI));
endmodule

// File: rtl/cfc_enable_bank.sv
module cfc_enable_bank #(
    parameter int NSETS = 2,
    parameter int SW    = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [SW-1:0] cfg_idx,
    input  logic          cfg_match_en,
    input  logic          cfg_full_en,
    input  logic [SW-1:0] act_sel,
    output logic          match_en,
    output logic          full_en,
    output logic          set_chg
);
    logic [NSETS-1:0] men_q, fen_q;
    logic [SW-1:0]    act_q;

    for (genvar g = 0; g < NSETS; g++) begin : g_set
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                men_q[g] <= 1'b1;
                fen_q[g] <= 1'b1;
            end else if (cfg_we && (cfg_idx == SW'(g))) begin
                men_q[g] <= cfg_match_en;
                fen_q[g] <= cfg_full_en;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_sel;
    end

    assign set_chg = (act_sel != act_q);

    always_comb begin
        match_en = 1'b0;
        full_en  = 1'b0;
        for (int i = 0; i < NSETS; i++) begin
            if (act_q == SW'(i)) begin
                match_en = men_q[i];
                full_en  = fen_q[i];
            end
        end
    end
endmodule

// File: rtl/cam_cascade_flags.sv
module cam_cascade_flags #(
    parameter int CW    = 4,
    parameter int NSETS = 2,
    localparam int SW   = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_n,
    input  logic          chain_en_n,
    input  logic          up_match_n,
    input  logic          up_full_n,
    input  logic          cmp_done,
    input  logic [CW-1:0] hit_count,
    input  logic          has_empty,
    input  logic          cfg_we,
    input  logic [SW-1:0] cfg_idx,
    input  logic          cfg_match_en,
    input  logic          cfg_full_en,
    input  logic [SW-1:0] act_sel,
    output logic          sys_match_n,
    output logic          dev_match_n,
    output logic          multi_match_n,
    output logic          full_n
);
    logic show, commit, set_chg, match_en, full_en, any_cur;

    cfc_enable_bank #(.NSETS(NSETS), .SW(SW)) u_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_match_en(cfg_match_en), .cfg_full_en(cfg_full_en),
        .act_sel(act_sel), .match_en(match_en), .full_en(full_en),
        .set_chg(set_chg)
    );

    cfc_strobe_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cyc_n(cyc_n), .chain_en_n(chain_en_n),
        .set_chg(set_chg), .show(show), .commit(commit)
    );

    cfc_hit_history #(.CW(CW)) u_hist (
        .clk(clk), .rst_n(rst_n), .commit(commit), .cmp_done(cmp_done),
        .set_chg(set_chg), .hit_count(hit_count), .any_cur(any_cur),
        .dev_match_n(dev_match_n), .multi_match_n(multi_match_n)
    );

    assign sys_match_n = show ? (match_en ? (up_match_n & ~any_cur) : up_match_n) : 1'b1;
    assign full_n      = full_en ? (up_full_n | has_empty) : up_full_n;
endmodule

// File: rtl/cfc_flag_checker.sv
module cfc_flag_checker #(
    parameter int SW = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          up_match_n,
    input logic          up_full_n,
    input logic [SW-1:0] act_sel,
    input logic          sys_match_n,
    input logic          dev_match_n,
    input logic          multi_match_n,
    input logic          full_n
);
    p_reset_idle_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (sys_match_n && dev_match_n && multi_match_n));

    p_no_unknown_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({sys_match_n, dev_match_n, multi_match_n, full_n}));

    p_match_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_match_n |-> (!up_match_n || !dev_match_n));

    p_multi_implies_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !multi_match_n |-> !dev_match_n);

    p_full_needs_upstream_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !up_full_n);

    p_switch_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_sel != $past(act_sel)) |=> (sys_match_n && dev_match_n && multi_match_n));
endmodule

bind cam_cascade_flags cfc_flag_checker #(.SW(SW)) u_flag_checker (
    .clk(clk), .rst_n(rst_n), .up_match_n(up_match_n), .up_full_n(up_full_n),
    .act_sel(act_sel), .sys_match_n(sys_match_n), .dev_match_n(dev_match_n),
    .multi_match_n(multi_match_n), .full_n(full_n)
);

// File: tb/test_cam_cascade_flags.sv
module test_cam_cascade_flags;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_n = 1'b1, chain_en_n = 1'b1, cmp_done = 1'b0, cfg_we = 1'b0;
    logic [0:0] cfg_idx = '0, act_sel = '0;
    logic [CW-1:0] hc [3];
    logic [2:0] emp = '0, cme = '0, cfe = '0;
    logic [2:0] mf, ma, mm, ff;

    int total = 0, bad = 0;
    bit done = 0;

    // model state
    int  cur [3], prev [3];
    bit  men [2][3], fen [2][3];
    int  aset = 0;
    bit  show = 0;

    always #4 clk = ~clk;

    cam_cascade_flags #(.CW(CW)) i_up0 (
        .clk(clk), .rst_n(rst_n), .cyc_n(cyc_n), .chain_en_n(chain_en_n),
        .up_match_n(1'b1), .up_full_n(1'b0), .cmp_done(cmp_done),
        .hit_count(hc[0]), .has_empty(emp[0]), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_match_en(cme[0]), .cfg_full_en(cfe[0]), .act_sel(act_sel),
        .sys_match_n(mf[0]), .dev_match_n(ma[0]), .multi_match_n(mm[0]), .full_n(ff[0]));
    cam_cascade_flags #(.CW(CW)) i_up1 (
        .clk(clk), .rst_n(rst_n), .cyc_n(cyc_n), .chain_en_n(chain_en_n),
        .up_match_n(mf[0]), .up_full_n(ff[0]), .cmp_done(cmp_done),
        .hit_count(hc[1]), .has_empty(emp[1]), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_match_en(cme[1]), .cfg_full_en(cfe[1]), .act_sel(act_sel),
        .sys_match_n(mf[1]), .dev_match_n(ma[1]), .multi_match_n(mm[1]), .full_n(ff[1]));
    cam_cascade_flags #(.CW(CW)) i_cam_cascade_flags (
        .clk(clk), .rst_n(rst_n), .cyc_n(cyc_n), .chain_en_n(chain_en_n),
        .up_match_n(mf[1]), .up_full_n(ff[1]), .cmp_done(cmp_done),
        .hit_count(hc[2]), .has_empty(emp[2]), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_match_en(cme[2]), .cfg_full_en(cfe[2]), .act_sel(act_sel),
        .sys_match_n(mf[2]), .dev_match_n(ma[2]), .multi_match_n(mm[2]), .full_n(ff[2]));

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_mf();
        logic mi = 1'b1;
        logic [2:0] r;
        for (int k = 0; k < 3; k++) begin
            r[k] = show ? (men[aset][k] ? (mi & (cur[k] == 0)) : mi) : 1'b1;
            mi = r[k];
        end
        return r;
    endfunction

    function automatic logic [2:0] exp_ff();
        logic fi = 1'b0;
        logic [2:0] r;
        for (int k = 0; k < 3; k++) begin
            r[k] = fen[aset][k] ? (fi | emp[k]) : fi;
            fi = r[k];
        end
        return r;
    endfunction

    function automatic logic [2:0] exp_ma();
        logic [2:0] r;
        for (int k = 0; k < 3; k++) r[k] = !(cur[k] >= 1 || prev[k] >= 1);
        return r;
    endfunction

    function automatic logic [2:0] exp_mm();
        logic [2:0] r;
        for (int k = 0; k < 3; k++) r[k] = !(cur[k] >= 2 || prev[k] >= 2);
        return r;
    endfunction

    // R10: write one set on all three devices
    task automatic wr_set(input int s, input logic [2:0] m, input logic [2:0] f);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 1'(s); cme = m; cfe = f;
        @(negedge clk);
        cfg_we = 1'b0;
        for (int k = 0; k < 3; k++) begin
            men[s][k] = m[k];
            fen[s][k] = f[k];
        end
    endtask

    task automatic strobe(input bit ec, input bit cmp, input int h0, input int h1,
                          input int h2, input bit swap);
        @(negedge clk);
        cyc_n = 1'b0; chain_en_n = ec;
        @(negedge clk);
        chk(ec ? "R2 low phase" : "R3 low phase", mf, 3'b111);
        cyc_n = 1'b1; cmp_done = cmp;
        hc[0] = CW'(h0); hc[1] = CW'(h1); hc[2] = CW'(h2);
        if (swap) act_sel = ~act_sel;
        @(negedge clk);
        if (swap) begin
            aset = 1 - aset;
            show = 0;
            for (int k = 0; k < 3; k++) begin cur[k] = 0; prev[k] = 0; end
            chk("R9 clear mf", mf, 3'b111);
            chk("R9 clear ma", ma, 3'b111);
            chk("R9 clear mm", mm, 3'b111);
        end else begin
            if (cmp) begin
                prev[0] = cur[0]; prev[1] = cur[1]; prev[2] = cur[2];
                cur[0] = h0; cur[1] = h1; cur[2] = h2;
            end
            show = !ec;
            chk(ec ? "R2 disabled mf" : "R3/R4/R11 chain mf", mf, exp_mf());
            chk(cmp ? "R5 ma" : "R7 ma held", ma, exp_ma());
            chk(cmp ? "R6 mm" : "R7 mm held", mm, exp_mm());
        end
        cmp_done = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 3; k++) begin
            hc[k] = '0; cur[k] = 0; prev[k] = 0;
            for (int s = 0; s < 2; s++) begin men[s][k] = 1; fen[s][k] = 1; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mf reset", mf, 3'b111);
        chk("R1 ma reset", ma, 3'b111);
        chk("R1 mm reset", mm, 3'b111);
        chk("R1 ff enables", ff, exp_ff());

        // R8/R11: full chain sweep over enables and empties
        for (int fc = 0; fc < 8; fc++) begin
            wr_set(0, 3'b111, 3'(fc));
            for (int e = 0; e < 8; e++) begin
                @(negedge clk);
                emp = 3'(e);
                #1;
                chk("R8/R11 full chain", ff, exp_ff());
            end
        end
        emp = 3'b000;

        // R2..R7, R11: chain enable x match enables x hit counts
        for (int ec = 0; ec < 2; ec++) begin
            for (int mc = 0; mc < 8; mc++) begin
                wr_set(0, 3'(mc), 3'b111);
                for (int hv = 0; hv < 64; hv++) begin
                    strobe(ec[0], (hv % 7) != 3, hv & 3, (hv >> 2) & 3, (hv >> 4) & 3, 1'b0);
                end
            end
        end

        // R9: set switch coinciding with a strobe rise
        wr_set(0, 3'b111, 3'b111);
        wr_set(1, 3'b001, 3'b000);
        strobe(1'b0, 1'b1, 2, 1, 3, 1'b0);
        chk("R9 pre-switch ma", ma, 3'b000);
        strobe(1'b0, 1'b1, 2, 2, 2, 1'b1);
        // new set: device0 enabled, others follow upstream (R4)
        strobe(1'b0, 1'b1, 1, 0, 0, 1'b0);
        chk("R9/R4 new set mf", mf, 3'b000);
        @(negedge clk);
        emp = 3'b111;
        #1;
        chk("R9/R8 new set ff", ff, exp_ff());
        strobe(1'b0, 1'b1, 0, 3, 3, 1'b0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule